// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block reads a run of bytes out of a one-time-programmable fuse array. The array sits behind a register-style port. One control register carries an address field, a ready flag and a data byte. A separate register holds the bank selection. A single start pulse launches a job. The sequencer first confirms that the fuse bank named by the caller is selected. It then walks the addresses upward, one byte at a time. For each address it writes the address, polls until the ready flag comes up and forwards the captured byte.

Each byte leaves the block as a one-cycle strobe, carrying the byte and its index within the job. A one-cycle completion pulse closes the job, whether every byte arrived or the job was abandoned. Two held flags give the reason for an abandoned job: the bank could not be selected, or a byte never became ready. The poll spacing and the give-up limit are parameters counted in clock cycles.

Top module: `fuse_rd_seq`

## Requirements
- R1: After a start, the first register access reads the bank register, whose bank field is bit 0 (0 = primary bank, 1 = secondary bank). When that field already equals `tgt_bank`, the job makes no write to the bank register.
- R2: When the bank field differs, the block writes `tgt_bank` into it and reads it back. If the read-back value still differs, the job ends with `fail_bank` set. The job issues no access to the control register.
- R3: When bank selection succeeds, the bank field holds `tgt_bank` before the first address is issued.
- R4: Each read is issued as one write to the control register. The address goes in bits [8 +: AW], and the ready flag (bit 31) is written as 0.
- R5: The captured byte is bits [7:0] of the first control-register read that shows bit 31 set. It appears on `out_byte` with a one-cycle `out_valid` strobe, and `out_idx` gives its position within the job.
- R6: Addresses run upward from `start_addr`, wrapping modulo 2^AW. The job issues exactly `byte_cnt` of them.
- R7: If ready is not seen within TIMEOUT cycles of issuing an address, the job ends with `fail_tmo` set. No further address is issued.
- R8: `done` is a one-cycle pulse in the cycle after the job leaves its busy phase. `busy` is high from the cycle after an accepted start until that pulse. Both fail flags are valid with `done` and stay until the next accepted start.
- R9: A `byte_cnt` of 0 performs bank selection only, then pulses `done` with no control-register access.
- R10: A start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | launch a job (accepted only when idle) |
| start_addr | input | AW | first fuse address |
| byte_cnt | input | CW | number of bytes to read |
| tgt_bank | input | 1 | bank to select (0 primary, 1 secondary) |
| busy | output | 1 | job in progress |
| done | output | 1 | one-cycle end-of-job pulse |
| out_valid | output | 1 | byte strobe |
| out_byte | output | 8 | captured byte |
| out_idx | output | CW | index of the byte within the job |
| fail_bank | output | 1 | bank selection failed |
| fail_tmo | output | 1 | a byte timed out |
| rq_valid | output | 1 | register access strobe |
| rq_write | output | 1 | 1 = write, 0 = read |
| rq_sel | output | 1 | 0 = control register, 1 = bank register |
| rq_wdata | output | 32 | write data |
| rsp_data | input | 32 | read data, valid the cycle after a read strobe |

## Verification
Some properties are checked on every cycle. Every control-register write carries a cleared ready flag. Byte indices count up without gaps from each accepted start. `done` never lasts more than one cycle, and it comes with every rising fail flag. No control access happens while a bank failure is still flagged. Other behaviour needs the bench's scenarios, run against a fuse model with adjustable latency. That covers skipping the bank write when the bank already matches, the stuck bank register, the ascending and wrapping address order, the abort on a byte that never becomes ready, the empty job and the ignored second start.

// File: rtl/fuse_rd_seq_pkg.sv
package fuse_rd_seq_pkg;
  localparam int RDY_BIT  = 31;
  localparam int ADDR_LSB = 8;
  localparam int BANK_BIT = 0;
  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_BANK = 1'b1;

  typedef enum logic [3:0] {
    S_IDLE, S_BRD, S_BCMP, S_BWR, S_BVRD, S_BVCMP,
    S_NEXT, S_ISSUE, S_GAP, S_PRD, S_PCHK, S_FIN
  } seq_state_t;
endpackage

// File: rtl/fsr_poll_timer.sv
module fsr_poll_timer #(
  parameter int GAP   = 100,
  parameter int LIMIT = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic gap_run,
  output logic gap_hit,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam int GW = $clog2(GAP + 1);

  logic [TW-1:0] total_q;
  logic [GW-1:0] gap_q;

  assign expired = (total_q >= TW'(LIMIT));
  assign gap_hit = gap_run && (gap_q == GW'(GAP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      gap_q   <= '0;
    end else begin
      if (restart)       total_q <= '0;
      else if (!expired) total_q <= total_q + 1'b1;
      if (!gap_run)      gap_q <= '0;
      else if (!gap_hit) gap_q <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/fsr_addr_walker.sv
module fsr_addr_walker #(
  parameter int AW = 10,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_idx,
  output logic          finished
);
  logic [CW-1:0] total_q;

  assign finished = (cur_idx == total_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_idx  <= '0;
      total_q  <= '0;
    end else if (load) begin
      cur_addr <= base;
      cur_idx  <= '0;
      total_q  <= count;
    end else if (step) begin
      cur_addr <= cur_addr + 1'b1;
      cur_idx  <= cur_idx + 1'b1;
    end
  end
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_seq_pkg::*;
#(
  parameter int AW       = 10,
  parameter int CW       = 11,
  parameter int POLL_GAP = 100,
  parameter int TIMEOUT  = 100_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] byte_cnt,
  input  logic          tgt_bank,
  output logic          busy,
  output logic          done,
  output logic          out_valid,
  output logic [7:0]    out_byte,
  output logic [CW-1:0] out_idx,
  output logic          fail_bank,
  output logic          fail_tmo,
  output logic          rq_valid,
  output logic          rq_write,
  output logic          rq_sel,
  output logic [31:0]   rq_wdata,
  input  logic [31:0]   rsp_data
);
  function automatic logic [31:0] ctrl_word(input logic [AW-1:0] a);
    logic [31:0] w;
    w = '0;
    w[ADDR_LSB +: AW] = a;
    w[RDY_BIT] = 1'b0;
    return w;
  endfunction

  function automatic logic [31:0] bank_word(input logic b);
    logic [31:0] w;
    w = '0;
    w[BANK_BIT] = b;
    return w;
  endfunction

  seq_state_t state_q, state_d;
  logic tgt_q, pend_bank_q, pend_tmo_q;

  // named internal events
  logic job_accept, bank_match, byte_ready, tmr_gap_hit, tmr_expired;
  logic walk_done, walk_step;
  logic [AW-1:0] walk_addr;
  logic [CW-1:0] walk_idx;

  assign job_accept = start && (state_q == S_IDLE);
  assign bank_match = (rsp_data[BANK_BIT] == tgt_q);
  assign byte_ready = (state_q == S_PCHK) && rsp_data[RDY_BIT];
  assign walk_step  = byte_ready;
  assign busy       = (state_q != S_IDLE);

  fsr_poll_timer #(.GAP(POLL_GAP), .LIMIT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .restart(state_q == S_ISSUE),
    .gap_run(state_q == S_GAP),
    .gap_hit(tmr_gap_hit),
    .expired(tmr_expired)
  );

  fsr_addr_walker #(.AW(AW), .CW(CW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .load(job_accept), .step(walk_step),
    .base(start_addr), .count(byte_cnt),
    .cur_addr(walk_addr), .cur_idx(walk_idx), .finished(walk_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start) state_d = S_BRD;
      S_BRD:   state_d = S_BCMP;
      S_BCMP:  state_d = bank_match ? S_NEXT : S_BWR;
      S_BWR:   state_d = S_BVRD;
      S_BVRD:  state_d = S_BVCMP;
      S_BVCMP: state_d = bank_match ? S_NEXT : S_FIN;
      S_NEXT:  state_d = walk_done ? S_FIN : S_ISSUE;
      S_ISSUE: state_d = S_GAP;
      S_GAP: begin
        if (tmr_expired)      state_d = S_FIN;
        else if (tmr_gap_hit) state_d = S_PRD;
      end
      S_PRD:   state_d = S_PCHK;
      S_PCHK: begin
        if (rsp_data[RDY_BIT]) state_d = S_NEXT;
        else if (tmr_expired)  state_d = S_FIN;
        else                   state_d = S_GAP;
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    rq_valid = 1'b0;
    rq_write = 1'b0;
    rq_sel   = SEL_CTRL;
    rq_wdata = '0;
    unique case (state_q)
      S_BRD, S_BVRD: begin rq_valid = 1'b1; rq_sel = SEL_BANK; end
      S_BWR: begin
        rq_valid = 1'b1; rq_write = 1'b1; rq_sel = SEL_BANK;
        rq_wdata = bank_word(tgt_q);
      end
      S_ISSUE: begin
        rq_valid = 1'b1; rq_write = 1'b1; rq_sel = SEL_CTRL;
        rq_wdata = ctrl_word(walk_addr);
      end
      S_PRD: begin rq_valid = 1'b1; rq_sel = SEL_CTRL; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      tgt_q       <= 1'b0;
      pend_bank_q <= 1'b0;
      pend_tmo_q  <= 1'b0;
      fail_bank   <= 1'b0;
      fail_tmo    <= 1'b0;
      done        <= 1'b0;
      out_valid   <= 1'b0;
      out_byte    <= '0;
      out_idx     <= '0;
    end else begin
      state_q   <= state_d;
      done      <= (state_q == S_FIN);
      out_valid <= byte_ready;
      if (byte_ready) begin
        out_byte <= rsp_data[7:0];
        out_idx  <= walk_idx;
      end
      if (job_accept) begin
        tgt_q       <= tgt_bank;
        pend_bank_q <= 1'b0;
        pend_tmo_q  <= 1'b0;
        fail_bank   <= 1'b0;
        fail_tmo    <= 1'b0;
      end
      if (state_q == S_BVCMP && !bank_match) pend_bank_q <= 1'b1;
      if ((state_q == S_GAP && tmr_expired) ||
          (state_q == S_PCHK && !rsp_data[RDY_BIT] && tmr_expired))
        pend_tmo_q <= 1'b1;
      if (state_q == S_FIN) begin
        fail_bank <= pend_bank_q;
        fail_tmo  <= pend_tmo_q;
      end
    end
  end
endmodule

// File: rtl/fuse_rd_seq_chk.sv
module fuse_rd_seq_chk #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          out_valid,
  input logic [CW-1:0] out_idx,
  input logic          fail_bank,
  input logic          fail_tmo,
  input logic          rq_valid,
  input logic          rq_write,
  input logic          rq_sel,
  input logic [31:0]   rq_wdata
);
  logic [CW-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                seen_q <= '0;
    else if (start && !busy)   seen_q <= '0;
    else if (out_valid)        seen_q <= seen_q + 1'b1;
  end

  assert_ready_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_write && !rq_sel) |-> !rq_wdata[31]);

  assert_idx_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_idx == seen_q));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_tmo_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_tmo) |-> done);

  assert_bank_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_bank) |-> done);

  assert_no_ctrl_on_bankfail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && !rq_sel) |-> !fail_bank);

  assert_byte_in_job_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (busy || done));
endmodule

bind fuse_rd_seq fuse_rd_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .out_valid(out_valid), .out_idx(out_idx), .fail_bank(fail_bank),
  .fail_tmo(fail_tmo), .rq_valid(rq_valid), .rq_write(rq_write),
  .rq_sel(rq_sel), .rq_wdata(rq_wdata)
);

// File: tb/sim_fuse_rd_seq.sv
module sim_fuse_rd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int CW = 11;
  localparam int GAP = 2;
  localparam int TMO = 40;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tgt_bank = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic busy, done, out_valid, fail_bank, fail_tmo;
  logic [7:0] out_byte;
  logic [CW-1:0] out_idx;
  logic rq_valid, rq_write, rq_sel;
  logic [31:0] rq_wdata;
  logic [31:0] rsp_data = '0;

  int checks = 0, fails = 0;
  int lat = 3, bank_wr = 0, ctrl_acc = 0;
  logic bank_q = 1'b0, bank_stuck = 1'b0, hang_en = 1'b0;
  logic [AW-1:0] hang_addr = '0, m_addr = '0;
  logic m_rdy = 1'b0;
  int m_cnt = 0;

  logic [CW+7:0] exp_bytes[$];
  logic [AW-1:0] exp_addr[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_rd_seq #(.AW(AW), .CW(CW), .POLL_GAP(GAP), .TIMEOUT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_cnt(byte_cnt), .tgt_bank(tgt_bank), .busy(busy), .done(done),
    .out_valid(out_valid), .out_byte(out_byte), .out_idx(out_idx),
    .fail_bank(fail_bank), .fail_tmo(fail_tmo), .rq_valid(rq_valid),
    .rq_write(rq_write), .rq_sel(rq_sel), .rq_wdata(rq_wdata),
    .rsp_data(rsp_data)
  );

  function automatic logic [7:0] fdata(logic [AW-1:0] a);
    return 8'((int'(a) * 37 + 11));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // fuse macro model
  always @(posedge clk) begin
    if (rq_valid && rq_write && rq_sel) begin
      if (!bank_stuck) bank_q <= rq_wdata[0];
    end else if (rq_valid && rq_write && !rq_sel) begin
      m_addr <= rq_wdata[8 +: AW];
      m_rdy  <= 1'b0;
      m_cnt  <= lat;
    end else if (!m_rdy && !(hang_en && m_addr == hang_addr)) begin
      if (m_cnt == 0) m_rdy <= 1'b1;
      else m_cnt <= m_cnt - 1;
    end
    if (rq_valid && !rq_write) begin
      if (rq_sel) rsp_data <= {31'b0, bank_q};
      else begin
        logic [31:0] w;
        w = '0;
        w[31] = m_rdy;
        w[8 +: AW] = m_addr;
        w[7:0] = fdata(m_addr);
        rsp_data <= w;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rq_valid && rq_write && rq_sel) bank_wr++;
      if (rq_valid && !rq_sel) ctrl_acc++;
      if (rq_valid && rq_write && !rq_sel) begin
        check(rq_wdata[31] == 1'b0, "R4 ready bit", int'(rq_wdata[31]), 0);
        if (exp_addr.size() == 0)
          check(1'b0, "R6/R7 unexpected address", int'(rq_wdata[8 +: AW]), -1);
        else begin
          logic [AW-1:0] ea;
          ea = exp_addr.pop_front();
          check(rq_wdata[8 +: AW] == ea, "R4/R6 address", int'(rq_wdata[8 +: AW]), int'(ea));
        end
      end
      if (out_valid) begin
        if (exp_bytes.size() == 0)
          check(1'b0, "R5 unexpected byte", int'(out_byte), -1);
        else begin
          logic [CW+7:0] e;
          e = exp_bytes.pop_front();
          check(out_byte == e[7:0], "R5 byte", int'(out_byte), int'(e[7:0]));
          check(out_idx == e[CW+7:8], "R5 index", int'(out_idx), int'(e[CW+7:8]));
        end
      end
    end
  end

  task automatic launch(input logic [AW-1:0] a, input int n, input logic b, input int stop_at);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] ad;
      ad = a + AW'(i);
      if (i <= stop_at) exp_addr.push_back(ad);
      if (i < stop_at) exp_bytes.push_back({CW'(i), fdata(ad)});
    end
    @(negedge clk);
    start = 1'b1; start_addr = a; byte_cnt = CW'(n); tgt_bank = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    check(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(done == 1'b1, req, int'(done), 1);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", int'(done), 0);
    check(exp_bytes.size() == 0 && exp_addr.size() == 0, "R6 exact count",
          exp_bytes.size() + exp_addr.size(), 0);
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !out_valid && !fail_bank && !fail_tmo, "R8 reset state",
          int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: bank already primary, no bank write
    bank_wr = 0; lat = 3;
    launch(10'd5, 4, 1'b0, 4);
    wait_done("R1 done");
    check(bank_wr == 0, "R1 no bank write", bank_wr, 0);
    check(!fail_bank && !fail_tmo, "R8 clean flags", int'(fail_bank), 0);

    // R3: switch to secondary bank
    bank_wr = 0; lat = 0;
    launch(10'd100, 3, 1'b1, 3);
    wait_done("R3 done");
    check(bank_wr == 1 && bank_q == 1'b1, "R3 bank switched", bank_wr, 1);

    // R2: stuck bank register
    bank_stuck = 1'b1; c0 = ctrl_acc;
    launch(10'd40, 3, 1'b0, -1);
    wait_done("R2 done");
    check(fail_bank == 1'b1, "R2 fail_bank", int'(fail_bank), 1);
    check(ctrl_acc == c0, "R2 no control access", ctrl_acc - c0, 0);
    bank_stuck = 1'b0;

    // R7: byte never ready aborts range
    hang_en = 1'b1; hang_addr = 10'd22; lat = 2;
    launch(10'd20, 5, 1'b0, 2);
    wait_done("R7 done");
    check(fail_tmo == 1'b1 && fail_bank == 1'b0, "R7 fail_tmo", int'(fail_tmo), 1);
    hang_en = 1'b0;

    // R7: slow but within limit
    lat = 20;
    launch(10'd60, 2, 1'b0, 2);
    wait_done("R7 slow done");
    check(fail_tmo == 1'b0, "R7 no timeout when slow", int'(fail_tmo), 0);

    // R9: empty job
    c0 = ctrl_acc; lat = 1;
    launch(10'd7, 0, 1'b0, 0);
    wait_done("R9 done");
    check(ctrl_acc == c0, "R9 no control access", ctrl_acc - c0, 0);

    // R6: wrap at top of address space
    launch(10'd1022, 4, 1'b0, 4);
    wait_done("R6 wrap done");

    // R10: second start while busy ignored
    launch(10'd300, 3, 1'b0, 3);
    repeat (2) @(negedge clk);
    start = 1'b1; start_addr = 10'd500; byte_cnt = CW'(6);
    @(negedge clk);
    start = 1'b0;
    wait_done("R10 done");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule